// File: doc/BRIEF.md
# Memory Port Bandwidth Monitor

This block sits beside a memory arbiter and measures how much traffic each requester gets. It watches a stream of request and grant events. Each event carries a 5-bit port number and a 4-bit device subport number. It keeps a global request count, a global grant count and four channel grant counts. A channel counts only the grants that pass its filter. In plain mode the filter looks at the port. In device mode it matches only the shared device port and then picks among that port's subports.

Counting can run freely, with reads returning the live counts. It can also run in timed windows of a programmed number of clock cycles. At the end of each window every count is frozen into a readable snapshot and the live counters start again from zero. A status flag, which also drives `irq`, is raised at the same time. Software clears the flag by writing the control word back with the flag bit set. All configuration and readback go through a word-addressed register bus with single-cycle writes and combinational reads.

Top module: `mem_bw_monitor`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While control word 0x20 bit 31 (enable) is clear, no counter changes on request or grant events.
- R3: While enabled, the request count (0x29) rises by one for each cycle with `ev_req` high, and the grant count (0x2a) rises by one for each cycle with `ev_gnt` high.
- R4: In plain mode (bit 23 of the channel's port register clear), channel k counts a grant when bit `ev_port` of its port register (0x21+2k) is set and bit `ev_sub` of its subport register (0x22+2k, 16 bits) is set. The count for channel k reads at 0x2b+k.
- R5: In device mode (bit 23 of the port register set), channel k counts only grants from port `DEV_PORT` (default 7) whose subport bit is set in its subport register. All other port-register bits are ignored.
- R6: Channel k counts only while bit k of the control word (bits 3:0) is set.
- R7: Each counter saturates at all ones of its width (32 bits by default) and does not wrap.
- R8: With control bit 20 (timed mode) set and a window length N > 0 written at 0x2f, the window ends on the Nth enabled cycle. At that point each count, including that cycle's events, is latched for readback and the live counters restart from zero. With bit 20 clear, the count registers read the live counts.
- R9: A window length of zero never ends a window.
- R10: Control bit 30 and `irq` are set when a window ends. Writing the control word with bit 30 set clears them. Writing it with bit 30 clear leaves them unchanged.
- R11: When a window ends in the same cycle as a flag-clearing write, the flag stays set.
- R12: A write of any value to a count register (0x29 to 0x2e) clears that counter, both its live value and its snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_req | input | 1 | Request event this cycle |
| ev_gnt | input | 1 | Grant event this cycle |
| ev_port | input | 5 | Port number of the event |
| ev_sub | input | 4 | Device subport number of the event |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Window-complete flag |

## Verification
The assertions assume that the clear strobes for the counters and the window timer come only from single-cycle bus writes. They also assume that the window length changes only through its own register write, since that write restarts the timer. The stimulus therefore issues at most one write per cycle, drives every event field to a known value on every cycle, and changes inputs only on the falling clock edge. Windows are kept short, so that expiry, a clear write and their collision all land on cycles the bench can count exactly.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
    localparam int REG_AW  = 6;
    localparam int NUM_CH  = 4;
    localparam int NUM_CNT = NUM_CH + 2;
    localparam int PORT_W  = 5;
    localparam int SUB_W   = 4;
    localparam int SUB_N   = 1 << SUB_W;

    localparam logic [REG_AW-1:0] A_CTRL = 6'h20;
    localparam logic [REG_AW-1:0] A_REQ  = 6'h29;
    localparam logic [REG_AW-1:0] A_WIN  = 6'h2f;

    localparam int B_EN    = 31;
    localparam int B_FLAG  = 30;
    localparam int B_TIMED = 20;
    localparam int B_DEV   = 23;

    typedef struct packed {
        logic              en;
        logic              timed;
        logic [NUM_CH-1:0] ch_en;
    } mon_ctrl_t;

    typedef struct packed {
        logic [31:0]      port_mask;
        logic [SUB_N-1:0] sub_mask;
    } chan_filt_t;

    function automatic logic [REG_AW-1:0] cnt_addr(int idx);
        return REG_AW'(int'(A_REQ) + idx);
    endfunction

    function automatic logic [REG_AW-1:0] port_addr(int ch);
        return REG_AW'(int'(A_CTRL) + 1 + 2 * ch);
    endfunction

    function automatic logic [REG_AW-1:0] sub_addr(int ch);
        return REG_AW'(int'(A_CTRL) + 2 + 2 * ch);
    endfunction

    function automatic logic filt_hit(chan_filt_t f, logic [PORT_W-1:0] port,
                                      logic [SUB_W-1:0] sub, logic [PORT_W-1:0] dev);
        if (f.port_mask[B_DEV])
            return (port == dev) && f.sub_mask[sub];
        return f.port_mask[port] && f.sub_mask[sub];
    endfunction
endpackage

// File: rtl/mbm_sat_counter.sv
module mbm_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic         roll,
    output logic [W-1:0] live,
    output logic [W-1:0] held
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] bumped;
    assign bumped = (inc && live != TOP) ? live + W'(1) : live;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            live <= '0;
            held <= '0;
        end else if (roll) begin
            held <= bumped;
            live <= '0;
        end else begin
            live <= bumped;
        end
    end

    // R7: a full counter stays full
    p_saturate_r7: assert property (@(posedge clk) disable iff (rst)
        (live == TOP && !clr && !roll) |=> (live == TOP));

    // R8: window end restarts the live count
    p_roll_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (roll && !clr) |=> (live == '0));

    // R12: a clear empties both copies
    p_clear_r12: assert property (@(posedge clk) disable iff (rst)
        clr |=> (live == '0 && held == '0));
endmodule

// File: rtl/mbm_window_timer.sv
module mbm_window_timer #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ld,
    input  logic [LEN_W-1:0] len,
    output logic             expire
);
    logic [LEN_W-1:0] cnt;

    assign expire = run && !ld && (len != '0) && (cnt == len - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst || ld || !run || len == '0 || expire)
            cnt <= '0;
        else
            cnt <= cnt + LEN_W'(1);
    end

    // R8: the cycle count never passes the programmed window
    p_cnt_in_window_r8: assert property (@(posedge clk) disable iff (rst)
        (len != '0) |-> (cnt < len));

    // R9: a stopped or zero-length timer sits at zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (len == '0 && !ld) |=> (cnt == '0));
endmodule

// File: rtl/mbm_regs.sv
module mbm_regs
    import mbm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [REG_AW-1:0]      addr,
    input  logic [31:0]            wdata,
    input  logic                   expire,
    output mon_ctrl_t              ctrl,
    output chan_filt_t             filt [NUM_CH],
    output logic [31:0]            win_len,
    output logic                   win_ld,
    output logic [NUM_CNT-1:0]     cnt_clr,
    output logic                   flag
);
    logic ctrl_wr, flag_clr;

    assign ctrl_wr  = we && (addr == A_CTRL);
    assign flag_clr = ctrl_wr && wdata[B_FLAG];
    assign win_ld   = we && (addr == A_WIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            win_len <= '0;
            flag    <= 1'b0;
        end else begin
            if (ctrl_wr)
                ctrl <= '{en: wdata[B_EN], timed: wdata[B_TIMED], ch_en: wdata[NUM_CH-1:0]};
            if (win_ld)
                win_len <= wdata;
            if (expire)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_filt
        always_ff @(posedge clk) begin
            if (rst) begin
                filt[k] <= '0;
            end else begin
                if (we && addr == port_addr(k))
                    filt[k].port_mask <= wdata;
                if (we && addr == sub_addr(k))
                    filt[k].sub_mask <= wdata[SUB_N-1:0];
            end
        end
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_clr
        assign cnt_clr[i] = we && (addr == cnt_addr(i));
    end

    // R10: window end raises the flag
    p_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag);

    // R10: flag holds until a clearing write
    p_flag_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    // R11: expiry beats a simultaneous clear
    p_flag_collide_r11: assert property (@(posedge clk) disable iff (rst)
        (expire && flag_clr) |=> flag);
endmodule

// File: rtl/mem_bw_monitor.sv
module mem_bw_monitor
    import mbm_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int DEV_PORT = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ev_req,
    input  logic        ev_gnt,
    input  logic [4:0]  ev_port,
    input  logic [3:0]  ev_sub,
    input  logic        reg_we,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam logic [PORT_W-1:0] DEV_ID = PORT_W'(DEV_PORT);

    mon_ctrl_t            ctrl;
    chan_filt_t           filt [NUM_CH];
    logic [31:0]          win_len;
    logic                 win_ld, expire, flag;
    logic [NUM_CNT-1:0]   cnt_clr, cnt_inc;
    logic [CNT_W-1:0]     live [NUM_CNT];
    logic [CNT_W-1:0]     held [NUM_CNT];
    logic [31:0]          view [NUM_CNT];

    mbm_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .expire(expire), .ctrl(ctrl), .filt(filt), .win_len(win_len),
        .win_ld(win_ld), .cnt_clr(cnt_clr), .flag(flag)
    );

    mbm_window_timer #(.LEN_W(32)) u_timer (
        .clk(clk), .rst(rst), .run(ctrl.en && ctrl.timed), .ld(win_ld),
        .len(win_len), .expire(expire)
    );

    assign cnt_inc[0] = ctrl.en && ev_req;
    assign cnt_inc[1] = ctrl.en && ev_gnt;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        assign cnt_inc[2+k] = ctrl.en && ctrl.ch_en[k] && ev_gnt &&
                              filt_hit(filt[k], ev_port, ev_sub, DEV_ID);

        // R6: a disabled channel keeps its count
        p_chan_idle_r6: assert property (@(posedge clk) disable iff (rst)
            (!ctrl.ch_en[k] && !cnt_clr[2+k] && !expire) |=> $stable(live[2+k]));
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        mbm_sat_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst(rst), .clr(cnt_clr[i]), .inc(cnt_inc[i]),
            .roll(expire), .live(live[i]), .held(held[i])
        );
        assign view[i] = ctrl.timed ? 32'(held[i]) : 32'(live[i]);
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL)
            reg_rdata = {ctrl.en, flag, 9'b0, ctrl.timed, 16'b0, ctrl.ch_en};
        if (reg_addr == A_WIN)
            reg_rdata = win_len;
        for (int i = 0; i < NUM_CNT; i++)
            if (reg_addr == cnt_addr(i))
                reg_rdata = view[i];
        for (int k = 0; k < NUM_CH; k++) begin
            if (reg_addr == port_addr(k))
                reg_rdata = filt[k].port_mask;
            if (reg_addr == sub_addr(k))
                reg_rdata = 32'(filt[k].sub_mask);
        end
    end

    assign irq = flag;

    // R2: nothing counts while the monitor is off
    p_gated_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !cnt_clr[1] && !expire) |=> $stable(live[1]));
endmodule

// File: tb/mem_bw_monitor_bench.sv
module mem_bw_monitor_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        ev_req, ev_gnt;
    logic [4:0]  ev_port;
    logic [3:0]  ev_sub;
    logic        reg_we;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        irq;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    mem_bw_monitor #(.CNT_W(8), .DEV_PORT(7)) u_mem_bw_monitor (
        .clk(clk), .rst(rst), .ev_req(ev_req), .ev_gnt(ev_gnt),
        .ev_port(ev_port), .ev_sub(ev_sub), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    typedef struct packed {
        logic [31:0] pm;
        logic [15:0] sm;
        logic [4:0]  port;
        logic [3:0]  sub;
        logic        hit;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h0000_0008, 16'hFFFF, 5'd3,  4'd5, 1'b1},
        '{32'h0000_0008, 16'h0001, 5'd3,  4'd5, 1'b0},
        '{32'h0000_0008, 16'hFFFF, 5'd4,  4'd5, 1'b0},
        '{32'h8000_0000, 16'hFFFF, 5'd31, 4'd0, 1'b1},
        '{32'h0080_0000, 16'h0004, 5'd7,  4'd2, 1'b1},
        '{32'h0080_0000, 16'h0004, 5'd7,  4'd3, 1'b0},
        '{32'h0080_0000, 16'h0004, 5'd23, 4'd2, 1'b0},
        '{32'h0080_0008, 16'hFFFF, 5'd3,  4'd0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic events(input logic rq, input logic gn, input logic [4:0] p,
                          input logic [3:0] s, input int n);
        ev_req = rq; ev_gnt = gn; ev_port = p; ev_sub = s;
        repeat (n) @(negedge clk);
        ev_req = 1'b0; ev_gnt = 1'b0; ev_port = '0; ev_sub = '0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        ev_req = 1'b0; ev_gnt = 1'b0; ev_port = '0; ev_sub = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(6'h20, v); check("R1 ctrl", v, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        rd(6'h2a, v); check("R1 grant count", v, 32'h0);
        rd(6'h21, v); check("R1 port filter", v, 32'h0);

        // R4/R5 filter table on channel 0, live readback (R8)
        wr(6'h20, 32'h8000_0001);
        for (int i = 0; i < 8; i++) begin
            wr(6'h21, VECS[i].pm);
            wr(6'h22, 32'(VECS[i].sm));
            wr(6'h2b, 32'h0);
            events(1'b0, 1'b1, VECS[i].port, VECS[i].sub, 1);
            rd(6'h2b, v);
            check($sformatf("R4/R5 filter vector %0d", i), v, 32'(VECS[i].hit));
        end

        // R3 global counts, then R12 clear by write
        wr(6'h29, 32'h0); wr(6'h2a, 32'h0);
        events(1'b1, 1'b0, 5'd0, 4'd0, 4);
        events(1'b0, 1'b1, 5'd9, 4'd1, 2);
        rd(6'h29, v); check("R3 request count", v, 32'd4);
        rd(6'h2a, v); check("R3 grant count", v, 32'd2);
        wr(6'h29, 32'h1234);
        rd(6'h29, v); check("R12 write clears", v, 32'd0);

        // R6 channel enable
        wr(6'h21, 32'h8); wr(6'h22, 32'hFFFF);
        wr(6'h23, 32'h8); wr(6'h24, 32'hFFFF);
        wr(6'h2b, 32'h0); wr(6'h2c, 32'h0);
        events(1'b0, 1'b1, 5'd3, 4'd0, 3);
        rd(6'h2b, v); check("R6 enabled channel", v, 32'd3);
        rd(6'h2c, v); check("R6 disabled channel", v, 32'd0);

        // R7 saturation at 8-bit width
        wr(6'h29, 32'h0);
        events(1'b1, 1'b0, 5'd0, 4'd0, 300);
        rd(6'h29, v); check("R7 saturate", v, 32'd255);

        // R2 disabled monitor
        wr(6'h20, 32'h0);
        wr(6'h2a, 32'h0);
        events(1'b1, 1'b1, 5'd3, 4'd0, 3);
        rd(6'h2a, v); check("R2 no count when off", v, 32'd0);

        // R8 timed window of 5 cycles
        wr(6'h29, 32'h0); wr(6'h2a, 32'h0); wr(6'h2b, 32'h0);
        wr(6'h2f, 32'd5);
        wr(6'h20, 32'h8010_000F);
        events(1'b0, 1'b1, 5'd3, 4'd0, 3);
        @(negedge clk);
        check("R8 no irq before window end", 32'(irq), 32'h0);
        @(negedge clk);
        check("R10 irq at window end", 32'(irq), 32'h1);
        rd(6'h2a, v); check("R8 grant snapshot", v, 32'd3);
        rd(6'h2b, v); check("R8 channel snapshot", v, 32'd3);
        rd(6'h29, v); check("R8 request snapshot", v, 32'd0);

        // R10 write with bit 30 clear keeps flag, with bit 30 set clears it
        wr(6'h20, 32'h0);
        check("R10 flag kept", 32'(irq), 32'h1);
        wr(6'h20, 32'h4000_0000);
        check("R10 flag cleared", 32'(irq), 32'h0);
        rd(6'h20, v); check("R10 ctrl readback", v, 32'h0);

        // R11 clear colliding with second window end
        wr(6'h20, 32'h8010_0001);
        repeat (9) @(negedge clk);
        wr(6'h20, 32'hC010_0001);
        check("R11 collision keeps flag", 32'(irq), 32'h1);
        wr(6'h20, 32'hC010_0001);
        check("R10 clear away from expiry", 32'(irq), 32'h0);
        wr(6'h20, 32'h0);

        // R9 zero-length window
        wr(6'h2f, 32'h0);
        wr(6'h20, 32'h8010_0000);
        repeat (30) @(negedge clk);
        check("R9 zero window never ends", 32'(irq), 32'h0);
        wr(6'h20, 32'h0);

        summary();
    end
endmodule